// File: doc/BRIEF.md
# Shift Unit with Carry

This block is the operand shifter of a 32-bit RISC datapath. From a 32-bit operand, a shift kind, a shift amount and a carry input, it produces the shifted value and the shifter carry-out. It also raises an invalid flag when the requested kind and amount do not make a legal combination. Every output is combinational.

Two small decoders sit beside the shifter. The immediate decoder pulls a 2-bit type field and a 5-bit amount out of an instruction word. A mode input picks either the wide or the narrow field layout. The decoder then turns a zero amount into the form that each kind really means. The register-shift decoder maps a bare 2-bit type to one of the four plain shift kinds. The decoder outputs are ports, so the datapath can feed either decoder into the shifter.

Top module: `shift_carry_unit`

## Requirements
- R1: Shift kinds are encoded on sh_kind as 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right and 4 = rotate-through-carry. For kinds 0 to 3 with sh_amt = 0, result equals opnd and c_out equals c_in.
- R2: Logical left by a nonzero amount n: the result is opnd shifted left, and it is zero for n ≥ 32. c_out is opnd bit (32 − n) for n ≤ 32 and 0 for larger n.
- R3: Logical right by a nonzero amount n: the result is opnd shifted right with zero fill, and it is zero for n ≥ 32. c_out is opnd bit (n − 1) for n ≤ 32 and 0 for larger n.
- R4: Arithmetic right by a nonzero amount n fills with opnd bit 31. For n ≥ 32, the result is 32 copies of bit 31 and c_out equals bit 31. Otherwise c_out is opnd bit (n − 1).
- R5: Rotate right by a nonzero amount n rotates by n modulo 32. c_out is bit 31 of the rotated result.
- R6: Rotate-through-carry with amount 1 returns {c_in, opnd[31:1]}, and c_out is opnd bit 0.
- R7: The invalid flag is 1 for kind 4 with any amount other than 1, and for kinds 5 to 7. When the flag is 1, result and c_out are both 0. In every other case the flag is 0.
- R8: The immediate decode maps the type field to a kind and an amount, written as imm_kind/imm_amt:
  - Type 0 gives kind 0 with the 5-bit amount.
  - Types 1 and 2 give kinds 1 and 2, with the 5-bit amount, or 32 when that amount is zero.
  - Type 3 gives kind 3 with the 5-bit amount, or kind 4 with amount 1 when that amount is zero.
- R9: The field positions depend on fmt_narrow.
  - With fmt_narrow = 0, the type is insn_word[6:5] and the amount is insn_word[11:7].
  - With fmt_narrow = 1, the type is insn_word[5:4] and the amount is {insn_word[14:12], insn_word[7:6]}.
- R10: The register-shift decode maps reg_type values 0, 1, 2 and 3 to kinds 0, 1, 2 and 3. It never yields kind 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_word | input | 32 | Instruction word holding the shift type and immediate amount |
| fmt_narrow | input | 1 | 1 selects the narrow field layout, 0 the wide one |
| imm_kind | output | 3 | Decoded shift kind from the immediate fields |
| imm_amt | output | AMT_W | Decoded effective shift amount |
| reg_type | input | 2 | Register-shift type field |
| reg_kind | output | 3 | Shift kind for a register-specified shift |
| opnd | input | 32 | Operand to shift |
| sh_kind | input | 3 | Shift kind to apply |
| sh_amt | input | AMT_W | Shift amount |
| c_in | input | 1 | Carry input |
| result | output | 32 | Shifted value |
| c_out | output | 1 | Shifter carry-out |
| invalid | output | 1 | Illegal kind/amount combination |

## Verification
Each shift kind is tried at amount 1 or a small amount, at exactly 32, and above 32. These three points separate the in-range bit selection from the saturating paths that yield zero or all sign bits and from the carry cutoff. Rotation uses amounts 8, 32 and 36, which shows that the amount is reduced modulo 32 and that the carry is taken from the rotated value. Zero amounts are applied with both carry-in values to show the pass-through. The decoder receives the same word in both layouts, to prove that each layout reads its own bits, and type 1 to 3 fields with a zero amount, to exercise the rewrites to 32 and to rotate-through-carry.

// File: rtl/shift_carry_unit.sv
module shift_carry_unit #(
  parameter int AMT_W = 8
) (
  input  logic [31:0]      insn_word,
  input  logic             fmt_narrow,
  output logic [2:0]       imm_kind,
  output logic [AMT_W-1:0] imm_amt,
  input  logic [1:0]       reg_type,
  output logic [2:0]       reg_kind,
  input  logic [31:0]      opnd,
  input  logic [2:0]       sh_kind,
  input  logic [AMT_W-1:0] sh_amt,
  input  logic             c_in,
  output logic [31:0]      result,
  output logic             c_out,
  output logic             invalid
);
  localparam logic [2:0] K_LSL = 3'd0;
  localparam logic [2:0] K_LSR = 3'd1;
  localparam logic [2:0] K_ASR = 3'd2;
  localparam logic [2:0] K_ROR = 3'd3;
  localparam logic [2:0] K_RRX = 3'd4;
  localparam logic [AMT_W-1:0] AMT_32 = AMT_W'(32);
  localparam logic [AMT_W-1:0] AMT_1  = AMT_W'(1);

  logic [1:0] f_type;
  logic [4:0] f_imm;
  assign f_type = fmt_narrow ? insn_word[5:4] : insn_word[6:5];
  assign f_imm  = fmt_narrow ? {insn_word[14:12], insn_word[7:6]} : insn_word[11:7];

  always_comb begin
    imm_kind = K_LSL;
    imm_amt  = AMT_W'(f_imm);
    case (f_type)
      2'd0: imm_kind = K_LSL;
      2'd1: begin
        imm_kind = K_LSR;
        if (f_imm == 5'd0) imm_amt = AMT_32;
      end
      2'd2: begin
        imm_kind = K_ASR;
        if (f_imm == 5'd0) imm_amt = AMT_32;
      end
      default: begin
        if (f_imm == 5'd0) begin
          imm_kind = K_RRX;
          imm_amt  = AMT_1;
        end else begin
          imm_kind = K_ROR;
        end
      end
    endcase
  end

  assign reg_kind = {1'b0, reg_type};

  logic [63:0]        lsl_w;
  logic [32:0]        lsr_w;
  logic signed [32:0] asr_w;
  logic [63:0]        ror_w;

  assign lsl_w = {32'b0, opnd} << sh_amt;
  assign lsr_w = {opnd, 1'b0} >> sh_amt;
  assign asr_w = $signed({opnd, 1'b0}) >>> sh_amt;
  assign ror_w = {opnd, opnd} >> sh_amt[4:0];

  always_comb begin
    invalid = 1'b0;
    result  = opnd;
    c_out   = c_in;
    if (sh_kind > K_RRX || (sh_kind == K_RRX && sh_amt != AMT_1)) begin
      invalid = 1'b1;
      result  = '0;
      c_out   = 1'b0;
    end else if (sh_kind == K_RRX) begin
      result = {c_in, opnd[31:1]};
      c_out  = opnd[0];
    end else if (sh_amt != '0) begin
      case (sh_kind)
        K_LSL: begin
          result = lsl_w[31:0];
          c_out  = lsl_w[32];
        end
        K_LSR: begin
          result = lsr_w[32:1];
          c_out  = lsr_w[0];
        end
        K_ASR: begin
          result = asr_w[32:1];
          c_out  = asr_w[0];
        end
        default: begin
          result = ror_w[31:0];
          c_out  = ror_w[31];
        end
      endcase
    end
  end
endmodule

module shift_carry_unit_chk #(
  parameter int AMT_W = 8
) (
  input logic [31:0]      insn_word,
  input logic             fmt_narrow,
  input logic [2:0]       imm_kind,
  input logic [AMT_W-1:0] imm_amt,
  input logic [1:0]       reg_type,
  input logic [2:0]       reg_kind,
  input logic [31:0]      opnd,
  input logic [2:0]       sh_kind,
  input logic [AMT_W-1:0] sh_amt,
  input logic             c_in,
  input logic [31:0]      result,
  input logic             c_out,
  input logic             invalid
);
  always_comb begin
    if (!$isunknown({sh_kind, sh_amt, opnd, c_in, result, c_out, invalid})) begin
      if (invalid)
        a_r7_invalid_zero: assert (result == '0 && c_out == 1'b0)
          else $error("R7 invalid output not cleared");
      if (sh_kind <= 3'd3 && sh_amt == '0)
        a_r1_zero_passthru: assert (result == opnd && c_out == c_in && !invalid)
          else $error("R1 zero amount not pass-through");
      if (sh_kind == 3'd4 && sh_amt == AMT_W'(1))
        a_r6_rrx_bits: assert (result[31] == c_in && c_out == opnd[0] && !invalid)
          else $error("R6 rotate-through-carry mismatch");
      if (sh_kind == 3'd0 && sh_amt >= AMT_W'(32))
        a_r2_lsl_wide_zero: assert (result == '0)
          else $error("R2 wide left shift not zero");
    end
    if (!$isunknown({imm_kind, imm_amt}))
      if (imm_kind == 3'd4)
        a_r8_rrx_amt_one: assert (imm_amt == AMT_W'(1))
          else $error("R8 decoded rotate-through-carry amount");
    if (!$isunknown(reg_kind))
      a_r10_reg_no_rrx: assert (reg_kind <= 3'd3)
        else $error("R10 register decode gave rotate-through-carry");
  end
endmodule

bind shift_carry_unit shift_carry_unit_chk #(.AMT_W(AMT_W)) chk_i (.*);

// File: tb/shift_carry_unit_tb.sv
`timescale 1ns/1ps
module shift_carry_unit_tb_top;
  localparam int AMT_W = 8;
  localparam int NV = 21;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0]      insn_word;
  logic             fmt_narrow;
  logic [2:0]       imm_kind;
  logic [AMT_W-1:0] imm_amt;
  logic [1:0]       reg_type;
  logic [2:0]       reg_kind;
  logic [31:0]      opnd;
  logic [2:0]       sh_kind;
  logic [AMT_W-1:0] sh_amt;
  logic             c_in;
  logic [31:0]      result;
  logic             c_out;
  logic             invalid;

  shift_carry_unit #(.AMT_W(AMT_W)) dut_i (
    .insn_word(insn_word), .fmt_narrow(fmt_narrow), .imm_kind(imm_kind), .imm_amt(imm_amt),
    .reg_type(reg_type), .reg_kind(reg_kind), .opnd(opnd), .sh_kind(sh_kind),
    .sh_amt(sh_amt), .c_in(c_in), .result(result), .c_out(c_out), .invalid(invalid)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // {req[3:0], kind[2:0], amt[7:0], cin, opnd[31:0], exp_res[31:0], exp_c, exp_inv}
  localparam logic [81:0] VEC [NV] = '{
    {4'd2,  3'd0, 8'd1,   1'b0, 32'h80000001, 32'h00000002, 1'b1, 1'b0}, // R2
    {4'd2,  3'd0, 8'd32,  1'b0, 32'h80000001, 32'h00000000, 1'b1, 1'b0}, // R2
    {4'd2,  3'd0, 8'd33,  1'b1, 32'h80000001, 32'h00000000, 1'b0, 1'b0}, // R2
    {4'd3,  3'd1, 8'd1,   1'b0, 32'h80000001, 32'h40000000, 1'b1, 1'b0}, // R3
    {4'd3,  3'd1, 8'd32,  1'b0, 32'h80000001, 32'h00000000, 1'b1, 1'b0}, // R3
    {4'd3,  3'd1, 8'd40,  1'b1, 32'h80000001, 32'h00000000, 1'b0, 1'b0}, // R3
    {4'd4,  3'd2, 8'd4,   1'b1, 32'h80000000, 32'hF8000000, 1'b0, 1'b0}, // R4
    {4'd4,  3'd2, 8'd32,  1'b0, 32'h80000000, 32'hFFFFFFFF, 1'b1, 1'b0}, // R4
    {4'd4,  3'd2, 8'd200, 1'b1, 32'h7FFFFFFF, 32'h00000000, 1'b0, 1'b0}, // R4
    {4'd4,  3'd2, 8'd3,   1'b0, 32'h0000000F, 32'h00000001, 1'b1, 1'b0}, // R4
    {4'd5,  3'd3, 8'd8,   1'b1, 32'h12345678, 32'h78123456, 1'b0, 1'b0}, // R5
    {4'd5,  3'd3, 8'd36,  1'b0, 32'h12345678, 32'h81234567, 1'b1, 1'b0}, // R5
    {4'd5,  3'd3, 8'd32,  1'b1, 32'h12345678, 32'h12345678, 1'b0, 1'b0}, // R5
    {4'd6,  3'd4, 8'd1,   1'b1, 32'h00000003, 32'h80000001, 1'b1, 1'b0}, // R6
    {4'd6,  3'd4, 8'd1,   1'b0, 32'h00000002, 32'h00000001, 1'b0, 1'b0}, // R6
    {4'd7,  3'd4, 8'd0,   1'b1, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b1}, // R7
    {4'd7,  3'd4, 8'd2,   1'b1, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b1}, // R7
    {4'd7,  3'd5, 8'd1,   1'b1, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b1}, // R7
    {4'd1,  3'd0, 8'd0,   1'b1, 32'hDEADBEEF, 32'hDEADBEEF, 1'b1, 1'b0}, // R1
    {4'd1,  3'd3, 8'd0,   1'b0, 32'hDEADBEEF, 32'hDEADBEEF, 1'b0, 1'b0}, // R1
    {4'd1,  3'd2, 8'd0,   1'b1, 32'h80000000, 32'h80000000, 1'b1, 1'b0}  // R1
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic dec(input logic [31:0] w, input logic narrow, input logic [2:0] ek,
                     input logic [7:0] ea, input string tag);
    @(negedge clk);
    insn_word = w;
    fmt_narrow = narrow;
    #1;
    chk(tag, {53'd0, imm_kind, imm_amt}, {53'd0, ek, ea});
  endtask

  initial begin
    insn_word = '0; fmt_narrow = 1'b0; reg_type = '0;
    opnd = '0; sh_kind = '0; sh_amt = '0; c_in = 1'b0;
    @(negedge clk); #1;
    chk("R1 idle state", {31'd0, result, c_out, invalid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sh_kind = VEC[i][77:75];
      sh_amt  = VEC[i][74:67];
      c_in    = VEC[i][66];
      opnd    = VEC[i][65:34];
      #1;
      chk($sformatf("R%0d vec%0d", VEC[i][81:78], i),
          {30'd0, result, c_out, invalid}, {30'd0, VEC[i][33:0]});
    end

    dec(32'h0000_0020, 1'b0, 3'd1, 8'd32, "R8 wide LSR zero->32");
    dec(32'h0000_0060, 1'b0, 3'd4, 8'd1,  "R8 wide type3 zero->RRX");
    dec(32'h0000_02E0, 1'b0, 3'd3, 8'd5,  "R8 wide ROR 5");
    dec(32'h0000_0000, 1'b0, 3'd0, 8'd0,  "R8 wide LSL 0");
    dec(32'h0000_0FC0, 1'b0, 3'd2, 8'd31, "R9 wide ASR 31");
    dec(32'h0000_50A0, 1'b1, 3'd2, 8'd22, "R9 narrow ASR 22");
    dec(32'h0000_0030, 1'b1, 3'd4, 8'd1,  "R8 narrow type3 zero->RRX");
    dec(32'h0000_0050, 1'b1, 3'd1, 8'd1,  "R9 narrow LSR 1");
    dec(32'h0000_0050, 1'b0, 3'd2, 8'd32, "R9 same word wide ASR 32");

    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      reg_type = t[1:0];
      #1;
      chk($sformatf("R10 reg type %0d", t), {61'd0, reg_kind}, 64'(t));
    end

    // R6 chained from narrow decoder: rotate-through-carry end to end
    @(negedge clk);
    insn_word = 32'h0000_0030; fmt_narrow = 1'b1;
    #1;
    sh_kind = imm_kind; sh_amt = imm_amt; opnd = 32'h0000_0001; c_in = 1'b0;
    #1;
    chk("R6 decoded RRX chain", {31'd0, result, c_out, invalid}, {31'd0, 32'h0, 1'b1, 1'b0});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule